// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This controller sits between a host register bus and an external byte-wide EEPROM. The host can read or write one EEPROM byte at a time through an address register, a data register and two self-clearing request bits. It can also start a burst that walks the EEPROM in sequence and copies the records it finds into on-chip memory. The EEPROM is reached through an abstract request/done handshake, so the serial wire protocol stays outside this block.

A burst reads three-byte records: a low address byte, a high address byte, then one data byte. Each record becomes one write on the memory port. The 24-bit memory address is made of a 9-bit base held by the host, the low 7 bits of the high address byte, and the whole low address byte. Bit 7 of the high address byte is dropped. A record whose two address bytes are both 0xFF ends the burst. Where a burst starts depends on history. After reset, with no access done yet, it starts at EEPROM address 0. After that, it starts one past the last EEPROM address touched by any operation.

Top module: `eeprom_burst_ctrl`

## Requirements
- R1: After reset every host register reads 0 (including the busy bit), `ee_req` is low and `mem_we` is low.
- R2: Host register offsets are: 0 control, 1 data, 2 address, 3 burst, 4 base. In the control register, bit 1 is the read request, bit 0 is the write request and bit 2 is the read-only busy flag. Writing control with bit 1 set while idle reads the EEPROM byte at the address register into the data register (bits 7:0, zero-extended). Bit 1 reads 1 until the byte has arrived and then clears itself.
- R3: Writing control with bit 0 set (and bit 1 clear) while idle writes the data register's byte to the EEPROM at the address register. Bit 0 reads 1 until the write is done and then clears itself.
- R4: When bits 1 and 0 are both set in one control write, only the read is carried out, and the EEPROM content is left unchanged.
- R5: `ee_req` stays high with `ee_addr`, `ee_we` and `ee_wdata` stable until the cycle in which `ee_done` is seen, and is low in the following cycle.
- R6: A burst starts at EEPROM address 0 if no EEPROM access has completed since reset. Otherwise it starts one past the last EEPROM address accessed by any single or burst operation.
- R7: For each burst record (low, high, data), `mem_we` pulses for one cycle, in the cycle after the data byte arrives. At that pulse `mem_addr` = {base[8:0], high[6:0], low[7:0]} and `mem_wdata` = the data byte. Bit 7 of the high byte is ignored.
- R8: Writing burst-register bit 0 while idle starts a burst, and the bit reads 1 until the burst ends. A record with low = high = 0xFF ends it, makes no memory write, and clears the bit. A burst never drives `ee_we`.
- R9: Only one operation runs at a time. A control or burst write that arrives while busy is ignored: no new access, no bit set.
- R10: Host writes to the address or data register while an access runs do not change that access's EEPROM address or write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_addr | input | 3 | Host register offset |
| bus_wdata | input | EE_AW | Host write data |
| bus_rdata | output | EE_AW | Host read data (combinational) |
| ee_req | output | 1 | EEPROM byte request, held until done |
| ee_we | output | 1 | 1 = write request, 0 = read request |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_rdata | input | 8 | Byte read, valid with ee_done |
| ee_done | input | 1 | One-cycle completion pulse |
| mem_we | output | 1 | On-chip memory write pulse |
| mem_addr | output | MEM_AW | On-chip memory address |
| mem_wdata | output | 8 | On-chip memory write byte |

## Verification
The bench targets the burst start address in three situations: fresh after reset, right after a previous burst, and after a single read. Records are placed at the places a wrong start would reach, so a design that always starts at 0, or that ignores single accesses, produces extra or missing memory writes. It sets bit 7 of a high address byte, so a design that keeps that bit produces a wrong memory address. It also stresses the busy window by rewriting address and data and by issuing control and burst requests in the middle of an access. A design that reads the live registers instead of a latched copy writes the wrong byte, and one that accepts requests while busy starts a second access or changes the data register.

// File: rtl/eeprom_burst_ctrl.sv
module eeprom_burst_ctrl #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int LOW_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [EE_AW-1:0]  bus_wdata,
  output logic [EE_AW-1:0]  bus_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic [7:0]        ee_rdata,
  input  logic              ee_done,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int BASE_W = MEM_AW - LOW_W;
  localparam int HI_W   = LOW_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_SGL, S_BRST} st_t;

  st_t              st;
  logic             rd_bit, wr_bit, touched;
  logic [EE_AW-1:0] addr_q, last_q;
  logic [7:0]       data_q, rec_lo, rec_hi;
  logic [BASE_W-1:0] base_q;
  logic [1:0]       idx;

  wire busy     = (st != S_IDLE);
  wire wr_ctl   = bus_wr && bus_addr == 3'd0;
  wire wr_data  = bus_wr && bus_addr == 3'd1;
  wire wr_addr  = bus_wr && bus_addr == 3'd2;
  wire wr_brst  = bus_wr && bus_addr == 3'd3;
  wire wr_base  = bus_wr && bus_addr == 3'd4;
  wire go_rd    = !busy && wr_ctl && bus_wdata[1];
  wire go_wr    = !busy && wr_ctl && !bus_wdata[1] && bus_wdata[0];
  wire go_brst  = !busy && wr_brst && bus_wdata[0];
  wire [EE_AW-1:0] start_ptr = touched ? last_q + 1'b1 : '0;
  wire rec_end  = (rec_lo == 8'hFF) && (ee_rdata == 8'hFF);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata[2:0] = {busy, rd_bit, wr_bit};
      3'd1: bus_rdata[7:0] = data_q;
      3'd2: bus_rdata = addr_q;
      3'd3: bus_rdata[0] = (st == S_BRST);
      3'd4: bus_rdata[BASE_W-1:0] = base_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rd_bit <= 1'b0;
      wr_bit <= 1'b0;
      touched <= 1'b0;
      addr_q <= '0;
      last_q <= '0;
      data_q <= '0;
      base_q <= '0;
      rec_lo <= '0;
      rec_hi <= '0;
      idx <= '0;
      ee_req <= 1'b0;
      ee_we <= 1'b0;
      ee_addr <= '0;
      ee_wdata <= '0;
      mem_we <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (wr_data) data_q <= bus_wdata[7:0];
      if (wr_addr) addr_q <= bus_wdata;
      if (wr_base) base_q <= bus_wdata[BASE_W-1:0];
      case (st)
        S_IDLE: begin
          if (go_rd || go_wr) begin
            st <= S_SGL;
            rd_bit <= go_rd;
            wr_bit <= go_wr;
            ee_req <= 1'b1;
            ee_we <= go_wr;
            ee_addr <= addr_q;
            ee_wdata <= data_q;
          end else if (go_brst) begin
            st <= S_BRST;
            idx <= '0;
            ee_req <= 1'b1;
            ee_we <= 1'b0;
            ee_addr <= start_ptr;
          end
        end
        S_SGL: begin
          if (ee_done) begin
            st <= S_IDLE;
            rd_bit <= 1'b0;
            wr_bit <= 1'b0;
            ee_req <= 1'b0;
            touched <= 1'b1;
            last_q <= ee_addr;
            if (!ee_we) data_q <= ee_rdata;
          end
        end
        S_BRST: begin
          if (ee_done) begin
            ee_req <= 1'b0;
            touched <= 1'b1;
            last_q <= ee_addr;
            ee_addr <= ee_addr + 1'b1;
            case (idx)
              2'd0: begin
                rec_lo <= ee_rdata;
                idx <= 2'd1;
              end
              2'd1: begin
                if (rec_end) st <= S_IDLE;
                else begin
                  rec_hi <= ee_rdata;
                  idx <= 2'd2;
                end
              end
              default: begin
                mem_we <= 1'b1;
                mem_addr <= {base_q, rec_hi[HI_W-1:0], rec_lo};
                mem_wdata <= ee_rdata;
                idx <= 2'd0;
              end
            endcase
          end else if (!ee_req) begin
            ee_req <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_done |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_done |=> !ee_req);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_req);

  // R7
  mem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(ee_done) && !$past(ee_we));

  // R8
  burst_rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRST) |-> !ee_we);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ee_done));
endmodule

// File: tb/test_eeprom_burst_ctrl.sv
module test_eeprom_burst_ctrl;
  localparam int AW = 16;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [AW-1:0] bus_wdata = '0;
  logic [AW-1:0] bus_rdata;
  logic ee_req, ee_we, mem_we;
  logic [AW-1:0] ee_addr;
  logic [7:0] ee_wdata, mem_wdata;
  logic [7:0] ee_rdata = '0;
  logic ee_done = 1'b0;
  logic [23:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  int ncap = 0;
  logic [7:0] mdl [1024];
  logic [7:0] expm [1024];
  logic [23:0] cap_a [16];
  logic [7:0] cap_d [16];

  always #4 clk = ~clk;

  eeprom_burst_ctrl i_eeprom_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ee_req(ee_req), .ee_we(ee_we),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata), .ee_done(ee_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      ee_done <= 1'b0;
      cnt <= 0;
    end else if (ee_done) begin
      ee_done <= 1'b0;
      cnt <= 0;
    end else if (ee_req) begin
      if (cnt == LAT - 1) begin
        ee_done <= 1'b1;
        ee_rdata <= mdl[ee_addr[9:0]];
        if (ee_we) mdl[ee_addr[9:0]] <= ee_wdata;
        cnt <= 0;
      end else cnt <= cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_we && ncap < 16) begin
      cap_a[ncap] <= mem_addr;
      cap_d[ncap] <= mem_wdata;
      ncap <= ncap + 1;
    end
  end

  function automatic logic [7:0] fill(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // {is_write, address, data or expected}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 16'h0100, 8'h3C}, {1'b0, 16'h0100, 8'h3C},
    {1'b0, 16'h0005, 8'h00}, {1'b1, 16'h03FF, 8'hA7},
    {1'b0, 16'h03FF, 8'hA7}, {1'b1, 16'h0002, 8'h00},
    {1'b0, 16'h0002, 8'h00}, {1'b0, 16'h0200, 8'h00}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = 3'(a);
    bus_wdata = AW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = 3'(a);
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    int v;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      rd(0, v);
      if (v[2] == 1'b0) break;
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) begin
      mdl[i] = fill(i);
      expm[i] = fill(i);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic place(int a, int lo, int hi, int d);
    mdl[a] = 8'(lo);
    mdl[a+1] = 8'(hi);
    mdl[a+2] = 8'(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, base;
    init_mem();
    do_reset();
    @(negedge clk);
    for (int r = 0; r < 5; r++) begin
      rd(r, v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 ee_req reset", int'(ee_req), 0);
    chk("R1 mem_we reset", int'(mem_we), 0);

    for (int n = 0; n < 8; n++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = VEC[n][23:8];
      d = VEC[n][7:0];
      wr(2, int'(a));
      if (VEC[n][24]) begin
        wr(1, int'(d));
        wr(0, 1);
        wait_idle();
        expm[a[9:0]] = d;
        chk("R3 byte written to EEPROM", int'(mdl[a[9:0]]), int'(d));
        rd(0, v);
        chk("R3 write bit self-clears", v, 0);
      end else begin
        wr(0, 2);
        wait_idle();
        rd(0, v);
        chk("R2 read bit self-clears", v, 0);
        rd(1, v);
        chk("R2 read data", v, int'(expm[a[9:0]]));
      end
    end

    // R4: both request bits -> read only
    wr(2, 16'h0033);
    wr(1, 8'h99);
    wr(0, 3);
    wait_idle();
    rd(1, v);
    chk("R4 read wins", v, int'(fill(16'h33)));
    chk("R4 EEPROM unchanged", int'(mdl[16'h33]), int'(fill(16'h33)));

    // R10: address and data rewritten during a read
    wr(2, 16'h0040);
    wr(0, 2);
    rd(0, v);
    chk("R2 read bit and busy while running", v, 6);
    wr(2, 16'h0041);
    wr(1, 8'h55);
    wait_idle();
    rd(1, v);
    chk("R10 read uses latched address", v, int'(fill(16'h40)));

    // R10 and R9: during a write
    wr(2, 16'h0050);
    wr(1, 8'h11);
    wr(0, 1);
    rd(0, v);
    chk("R3 write bit and busy while running", v, 5);
    wr(1, 8'h22);
    wr(0, 2);
    wr(3, 1);
    wait_idle();
    chk("R10 write uses latched data", int'(mdl[16'h50]), 8'h11);
    rd(1, v);
    chk("R9 read request ignored while busy", v, 8'h22);
    rd(3, v);
    chk("R9 burst request ignored while busy", v, 0);
    chk("R9 no memory write from ignored burst", ncap, 0);

    // Burst tests from a fresh reset
    init_mem();
    place(0, 8'h34, 8'h92, 8'hA5);
    place(3, 8'h01, 8'h00, 8'h5A);
    mdl[6] = 8'hFF; mdl[7] = 8'hFF;
    place(8, 8'h10, 8'h00, 8'h77);
    mdl[11] = 8'hFF; mdl[12] = 8'hFF;
    place(13, 8'h99, 8'h00, 8'h66);
    mdl[16] = 8'hFF; mdl[17] = 8'hFF;
    mdl[16'h21] = 8'hFF; mdl[16'h22] = 8'hFF;
    place(16'h23, 8'h05, 8'h01, 8'h3C);
    mdl[16'h26] = 8'hFF; mdl[16'h27] = 8'hFF;
    do_reset();
    base = 9'h1AB;
    wr(4, base);
    rd(4, v);
    chk("R2 base register", v, base);
    ncap = 0;
    wr(3, 1);
    rd(3, v);
    chk("R8 burst bit set while running", v, 1);
    wait_idle();
    rd(3, v);
    chk("R8 burst bit clears at end", v, 0);
    chk("R6 R8 first burst from 0 makes two writes", ncap, 2);
    chk("R7 address with high bit 7 ignored", int'(cap_a[0]), (base << 15) | (8'h12 << 8) | 8'h34);
    chk("R7 data byte", int'(cap_d[0]), 8'hA5);
    chk("R7 second record address", int'(cap_a[1]), (base << 15) | 8'h01);
    chk("R7 second record data", int'(cap_d[1]), 8'h5A);

    wr(3, 1);
    wait_idle();
    chk("R6 second burst continues after end", ncap, 3);
    chk("R6 second burst address", int'(cap_a[2]), (base << 15) | 8'h10);
    chk("R6 second burst data", int'(cap_d[2]), 8'h77);

    wr(2, 16'h0020);
    wr(0, 2);
    wait_idle();
    wr(3, 1);
    wait_idle();
    chk("R6 R8 burst after single read hits terminator", ncap, 3);
    wr(3, 1);
    wait_idle();
    chk("R6 next burst continues after terminator", ncap, 4);
    chk("R7 fourth record address", int'(cap_a[3]), (base << 15) | (8'h01 << 8) | 8'h05);
    chk("R7 fourth record data", int'(cap_d[3]), 8'h3C);
    chk("R5 request low when idle", int'(ee_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule